// File: doc/BRIEF.md
# Single-Source Interrupt Call Injector

This block sits next to the fetch stage of a small in-order core and turns one hardware event into an ordinary call. The event comes from one of two sources, and software picks which one. The first is an internal down-counting timer. The second is a conditioned event line coming from a pin. When an event is pending and the next instruction is being handed over, the block drops that instruction and makes the core perform a call-with-link in its place.

The call does three things in the same cycle:
- It writes the current C and Z flags and the address of the dropped instruction into a fixed link register.
- It redirects fetch to the address held in a fixed vector register.
- It loads C and Z from that vector word.

A handler returns through the matching return-with-flags request, which restores the flags and the program counter from the link word. There is no interrupt mode, no nesting and no priority logic. A programmable hold-off window keeps injections from following one another too closely.

Configuration is a three-entry write port:
- Address 0 is control: bit 0 enables injection, bit 1 selects the source (0 for the timer, 1 for the pin), and writing 1 to bit 2 discards a latched event.
- Address 1 holds the timer period.
- Address 2 holds the hold-off length.

Top module: `irq_call_injector`

## Requirements
- R1: After reset the block is disabled, with nothing pending and the hold-off counter at zero. Fetched instructions pass through (`issue_valid` follows `fetch_valid`), and no write or redirect is issued, even if a pin edge arrives.
- R2: The block injects in a cycle where it is enabled, an event is pending, the hold-off counter is zero and `fetch_valid` is high. In that cycle `inject` is high, `issue_valid` is low and the link register (address `LINK_ADDR`) is written. The link word has bits 31:22 at zero, C in bit 21, Z in bit 20 and `fetch_pc` in bits 19:0. The pending event is then cleared.
- R3: In the injection cycle `redir_pc` equals bits 19:0 of the vector word, `flag_c` equals its bit 21 and `flag_z` equals its bit 20.
- R4: With the pin source selected, a rising edge on `pin_evt` is latched as pending one clock later. A level that is held high counts only once.
- R5: With the timer source selected and the block enabled, a period value P produces one event every P+1 cycles. The first injection falls P+1 cycles after the enabling write.
- R6: With hold-off value H, no injection occurs in the H cycles that follow an injection. A still-pending event is therefore taken exactly H+1 cycles later.
- R7: Clearing the enable bit blocks injection but keeps a latched event. That event is taken at the first fetch after the block is enabled again.
- R8: A control write with bit 2 set discards a latched event. A new event that arrives in the cycle of an injection stays pending.
- R9: While `ret_req` is high, the block redirects to bits 19:0 of the link word, drives `flag_c` from its bit 21 and `flag_z` from its bit 20, and suppresses injection in that cycle.
- R10: No injection occurs while `fetch_valid` is low. The pending event waits for the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration entry select |
| cfg_wdata | input | CNT_W | Configuration write data |
| pin_evt | input | 1 | Conditioned pin event line |
| fetch_valid | input | 1 | Fetch stage is handing over an instruction |
| fetch_pc | input | 20 | Address of the instruction being handed over |
| cur_c | input | 1 | Current carry flag |
| cur_z | input | 1 | Current zero flag |
| ret_req | input | 1 | Core decoded a return-with-flags |
| vec_rd_data | input | 32 | Vector register read data |
| link_rd_data | input | 32 | Link register read data |
| issue_valid | output | 1 | Fetched instruction may issue |
| inject | output | 1 | Synthetic call replaces this fetch |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_addr | output | RF_AW | Register-file write address |
| rf_wr_data | output | 32 | Packed flags and return address |
| rf_rd_vec_addr | output | RF_AW | Read address of the vector register |
| rf_rd_link_addr | output | RF_AW | Read address of the link register |
| redir_valid | output | 1 | Fetch redirect and flag load this cycle |
| redir_pc | output | 20 | Redirect target |
| flag_c | output | 1 | Carry value to load |
| flag_z | output | 1 | Zero value to load |

## Verification
Injection, the link write, the redirect and the return path are all combinational. They are due in the same cycle as the fetch or return request, so the bench drives inputs just after the falling edge and samples one nanosecond later. Every latched effect (pin edge, timer zero, configuration write) shows up one rising edge later. The timer and hold-off sweeps therefore count cycles from a known falling edge and compare the index of each injection with P+1 or H+1, computed in the bench.

// File: rtl/irqi_pkg.sv
package irqi_pkg;
  localparam int XLEN  = 32;
  localparam int PC_W  = 20;
  localparam int PAD_W = XLEN - PC_W - 2;

  localparam int FLAG_Z_BIT = PC_W;
  localparam int FLAG_C_BIT = PC_W + 1;

  localparam logic [1:0] CFG_CTRL   = 2'd0;
  localparam logic [1:0] CFG_PERIOD = 2'd1;
  localparam logic [1:0] CFG_HOLD   = 2'd2;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_SRC = 1;
  localparam int CTRL_CLR = 2;

  function automatic logic [XLEN-1:0] pack_link(input logic c, input logic z,
                                                input logic [PC_W-1:0] pc);
    return {{PAD_W{1'b0}}, c, z, pc};
  endfunction
endpackage

// File: rtl/irqi_cfg.sv
module irqi_cfg
  import irqi_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic             ctl_en,
  output logic             ctl_src_pin,
  output logic             clr_pulse,
  output logic             period_wr,
  output logic [CNT_W-1:0] period_val,
  output logic [CNT_W-1:0] hold_val
);
  logic             en_q, en_d, src_q, src_d;
  logic [CNT_W-1:0] per_q, per_d, hold_q, hold_d;
  logic             wr_ctrl, wr_per, wr_hold;

  assign wr_ctrl = cfg_we && (cfg_addr == CFG_CTRL);
  assign wr_per  = cfg_we && (cfg_addr == CFG_PERIOD);
  assign wr_hold = cfg_we && (cfg_addr == CFG_HOLD);

  always_comb begin
    en_d   = en_q;
    src_d  = src_q;
    per_d  = per_q;
    hold_d = hold_q;
    if (wr_ctrl) begin
      en_d  = cfg_wdata[CTRL_EN];
      src_d = cfg_wdata[CTRL_SRC];
    end
    if (wr_per)  per_d  = cfg_wdata;
    if (wr_hold) hold_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      src_q  <= 1'b0;
      per_q  <= '0;
      hold_q <= '0;
    end else begin
      en_q   <= en_d;
      src_q  <= src_d;
      per_q  <= per_d;
      hold_q <= hold_d;
    end
  end

  assign ctl_en      = en_q;
  assign ctl_src_pin = src_q;
  assign clr_pulse   = wr_ctrl & cfg_wdata[CTRL_CLR];
  assign period_wr   = wr_per;
  assign period_val  = per_q;
  assign hold_val    = hold_q;
endmodule

// File: rtl/irqi_evt.sv
module irqi_evt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_timer,
  input  logic             src_pin,
  input  logic [CNT_W-1:0] period,
  input  logic             reload,
  input  logic             pin_evt,
  input  logic             clr,
  input  logic             take,
  output logic             pending
);
  logic [CNT_W-1:0] tcnt_q, tcnt_d;
  logic             prev_q, pend_q, pend_d;
  logic             tmr_pulse, pin_edge;

  assign tmr_pulse = run_timer & ~reload & (tcnt_q == '0);
  assign pin_edge  = src_pin & pin_evt & ~prev_q;

  always_comb begin
    if (!run_timer || reload || (tcnt_q == '0)) tcnt_d = period;
    else                                        tcnt_d = tcnt_q - 1'b1;
    pend_d = (tmr_pulse | pin_edge) | (pend_q & ~take & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      tcnt_q <= tcnt_d;
      prev_q <= pin_evt;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/irqi_holdoff.sv
module irqi_holdoff #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [CNT_W-1:0] hold_val,
  output logic             ready
);
  logic [CNT_W-1:0] hcnt_q, hcnt_d;
  logic             hcnt_ce;

  assign hcnt_ce = take | (hcnt_q != '0);

  always_comb begin
    if (take) hcnt_d = hold_val;
    else      hcnt_d = hcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hcnt_q <= '0;
    else if (hcnt_ce) hcnt_q <= hcnt_d;
  end

  assign ready = (hcnt_q == '0);
endmodule

// File: rtl/irq_call_injector.sv
module irq_call_injector
  import irqi_pkg::*;
#(
  parameter int               CNT_W     = 16,
  parameter int               RF_AW     = 9,
  parameter logic [RF_AW-1:0] LINK_ADDR = 9'h1F0,
  parameter logic [RF_AW-1:0] VEC_ADDR  = 9'h1F1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             pin_evt,
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic             cur_c,
  input  logic             cur_z,
  input  logic             ret_req,
  input  logic [XLEN-1:0]  vec_rd_data,
  input  logic [XLEN-1:0]  link_rd_data,
  output logic             issue_valid,
  output logic             inject,
  output logic             rf_wr_en,
  output logic [RF_AW-1:0] rf_wr_addr,
  output logic [XLEN-1:0]  rf_wr_data,
  output logic [RF_AW-1:0] rf_rd_vec_addr,
  output logic [RF_AW-1:0] rf_rd_link_addr,
  output logic             redir_valid,
  output logic [PC_W-1:0]  redir_pc,
  output logic             flag_c,
  output logic             flag_z
);
  logic             ctl_en, ctl_src_pin, clr_pulse, period_wr;
  logic [CNT_W-1:0] period_val, hold_val;
  logic             pending, hold_ready, take;
  logic [XLEN-1:0]  tgt_word;
  logic             unused_hi;

  irqi_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ctl_en(ctl_en), .ctl_src_pin(ctl_src_pin),
    .clr_pulse(clr_pulse), .period_wr(period_wr), .period_val(period_val),
    .hold_val(hold_val)
  );

  irqi_evt #(.CNT_W(CNT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .run_timer(ctl_en & ~ctl_src_pin),
    .src_pin(ctl_src_pin), .period(period_val), .reload(period_wr),
    .pin_evt(pin_evt), .clr(clr_pulse), .take(take), .pending(pending)
  );

  irqi_holdoff #(.CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .take(take), .hold_val(hold_val),
    .ready(hold_ready)
  );

  assign take = ctl_en & pending & hold_ready & fetch_valid & ~ret_req;

  assign inject          = take;
  assign issue_valid     = fetch_valid & ~take;
  assign rf_wr_en        = take;
  assign rf_wr_addr      = LINK_ADDR;
  assign rf_wr_data      = pack_link(cur_c, cur_z, fetch_pc);
  assign rf_rd_vec_addr  = VEC_ADDR;
  assign rf_rd_link_addr = LINK_ADDR;

  assign tgt_word    = ret_req ? link_rd_data : vec_rd_data;
  assign redir_valid = take | ret_req;
  assign redir_pc    = tgt_word[PC_W-1:0];
  assign flag_c      = tgt_word[FLAG_C_BIT];
  assign flag_z      = tgt_word[FLAG_Z_BIT];

  assign unused_hi = ^tgt_word[XLEN-1:PC_W+2];
endmodule

// File: rtl/irqi_chk.sv
module irqi_chk
  import irqi_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_valid,
  input logic             ret_req,
  input logic [XLEN-1:0]  link_rd_data,
  input logic             issue_valid,
  input logic             inject,
  input logic             rf_wr_en,
  input logic             redir_valid,
  input logic [PC_W-1:0]  redir_pc,
  input logic             ctl_en,
  input logic             pending,
  input logic [CNT_W-1:0] hold_val
);
  AST_TAKE_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    inject |-> (fetch_valid && !issue_valid && rf_wr_en)); // R10

  AST_TAKE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    inject |-> pending); // R2

  AST_MASKED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> !inject); // R7

  AST_HOLDOFF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inject && hold_val != '0) |=> !inject); // R6

  AST_RET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |-> (!inject && redir_valid && redir_pc == link_rd_data[PC_W-1:0])); // R9

  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (inject && !pending) |-> 1'b0); // R2
endmodule

bind irq_call_injector irqi_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .ret_req(ret_req),
  .link_rd_data(link_rd_data), .issue_valid(issue_valid), .inject(inject),
  .rf_wr_en(rf_wr_en), .redir_valid(redir_valid), .redir_pc(redir_pc),
  .ctl_en(ctl_en), .pending(pending), .hold_val(hold_val)
);

// File: tb/sim_irq_call_injector.sv
module sim_irq_call_injector;
  import irqi_pkg::*;

  logic        clk, rst_n, cfg_we, pin_evt, fetch_valid, cur_c, cur_z, ret_req;
  logic [1:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [19:0] fetch_pc, redir_pc;
  logic [31:0] vec_rd_data, link_rd_data, rf_wr_data;
  logic        issue_valid, inject, rf_wr_en, redir_valid, flag_c, flag_z;
  logic [8:0]  rf_wr_addr, rf_rd_vec_addr, rf_rd_link_addr;
  int nvec = 0;
  int nfail = 0;

  irq_call_injector u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pin_evt(pin_evt), .fetch_valid(fetch_valid),
    .fetch_pc(fetch_pc), .cur_c(cur_c), .cur_z(cur_z), .ret_req(ret_req),
    .vec_rd_data(vec_rd_data), .link_rd_data(link_rd_data),
    .issue_valid(issue_valid), .inject(inject), .rf_wr_en(rf_wr_en),
    .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
    .rf_rd_vec_addr(rf_rd_vec_addr), .rf_rd_link_addr(rf_rd_link_addr),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .flag_c(flag_c),
    .flag_z(flag_z)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic latch_pin();
    @(negedge clk); pin_evt = 1'b1; fetch_valid = 1'b0;
    @(negedge clk); pin_evt = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; pin_evt = 1'b0;
    fetch_valid = 1'b1; fetch_pc = 20'h00100; cur_c = 1'b0; cur_z = 1'b0;
    ret_req = 1'b0; vec_rd_data = 32'h0000_4000; link_rd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 inject", inject, 0);
    chk("R1 pass", issue_valid, 1);
    chk("R1 redir", redir_valid, 0);
    chk("R1 wr", rf_wr_en, 0);
    latch_pin();
    @(negedge clk); fetch_valid = 1'b1; #1;
    chk("R1 edge while off", inject, 0);

    // pin source, sweep flags of core and of vector word
    cfg_write(CFG_CTRL, 16'h0007);
    for (int v = 0; v < 4; v++) begin
      for (int f = 0; f < 4; f++) begin
        logic [19:0] pc, vpc;
        pc  = 20'h00400 + 20'(v * 37 + f * 5);
        vpc = 20'h80000 | 20'(v * 16 + f);
        latch_pin();
        @(negedge clk);
        fetch_valid = 1'b1; fetch_pc = pc; cur_c = f[1]; cur_z = f[0];
        vec_rd_data = {10'b0, v[1], v[0], vpc};
        #1;
        chk("R4 taken", inject, 1);
        chk("R2 displaced", issue_valid, 0);
        chk("R2 wr", rf_wr_en, 1);
        chk("R2 addr", rf_wr_addr, rf_rd_link_addr);
        chk("R2 word", rf_wr_data, {10'b0, f[1], f[0], pc});
        chk("R3 pc", redir_pc, vpc);
        chk("R3 c", flag_c, v[1]);
        chk("R3 z", flag_z, v[0]);
        @(negedge clk); #1;
        chk("R2 cleared", inject, 0);
        chk("R2 pass", issue_valid, 1);
        fetch_valid = 1'b0;
      end
    end

    // level held high counts once
    @(negedge clk); pin_evt = 1'b1; fetch_valid = 1'b0;
    @(negedge clk); fetch_valid = 1'b1; #1;
    chk("R4 level first", inject, 1);
    @(negedge clk); #1;
    chk("R4 level once", inject, 0);
    @(negedge clk); pin_evt = 1'b0; fetch_valid = 1'b0;

    // waits for fetch
    latch_pin();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R10 no fetch", inject, 0);
    end
    @(negedge clk); fetch_valid = 1'b1; #1;
    chk("R10 taken later", inject, 1);
    @(negedge clk); fetch_valid = 1'b0;

    // disable keeps pending
    cfg_write(CFG_CTRL, 16'h0002);
    latch_pin();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); fetch_valid = 1'b1; #1;
      chk("R7 masked", inject, 0);
      chk("R7 pass", issue_valid, 1);
    end
    fetch_valid = 1'b0;
    cfg_write(CFG_CTRL, 16'h0003);
    fetch_valid = 1'b1; #1;
    chk("R7 taken after enable", inject, 1);
    @(negedge clk); fetch_valid = 1'b0;

    // clear discards
    latch_pin();
    cfg_write(CFG_CTRL, 16'h0007);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); fetch_valid = 1'b1; #1;
      chk("R8 discarded", inject, 0);
    end
    fetch_valid = 1'b0;

    // hold-off sweep, with event arriving on the take cycle
    for (int h = 0; h < 6; h++) begin
      int got;
      cfg_write(CFG_HOLD, 16'(h));
      repeat (8) @(negedge clk);
      latch_pin();
      @(negedge clk); pin_evt = 1'b1; fetch_valid = 1'b1; #1;
      chk("R6 first", inject, 1);
      got = 0;
      for (int k = 1; k <= 12; k++) begin
        @(negedge clk); pin_evt = 1'b0; fetch_valid = 1'b1; #1;
        if (inject && got == 0) got = k;
      end
      fetch_valid = 1'b0;
      chk("R8 R6 gap", got, h + 1);
    end
    cfg_write(CFG_HOLD, 16'h0000);
    repeat (8) @(negedge clk);

    // return path wins over pending injection
    latch_pin();
    @(negedge clk);
    fetch_valid = 1'b1; ret_req = 1'b1; link_rd_data = {10'b0, 1'b1, 1'b0, 20'h0ABCD};
    #1;
    chk("R9 no inject", inject, 0);
    chk("R9 redir", redir_valid, 1);
    chk("R9 pc", redir_pc, 20'h0ABCD);
    chk("R9 c", flag_c, 1);
    chk("R9 z", flag_z, 0);
    @(negedge clk); ret_req = 1'b0; #1;
    chk("R9 pending kept", inject, 1);
    @(negedge clk); fetch_valid = 1'b0;

    // timer sweep
    for (int p = 0; p < 5; p++) begin
      int first, prev, n;
      cfg_write(CFG_CTRL, 16'h0004);
      cfg_write(CFG_PERIOD, 16'(p));
      cfg_write(CFG_CTRL, 16'h0005);
      first = -1; prev = -1; n = 0;
      for (int k = 0; k < 4 * (p + 1) + 2; k++) begin
        if (k > 0) @(negedge clk);
        fetch_valid = 1'b1; #1;
        if (inject) begin
          if (first < 0) first = k;
          else if (n < 3) begin chk("R5 interval", k - prev, p + 1); n++; end
          prev = k;
        end
      end
      fetch_valid = 1'b0;
      chk("R5 first", first, p + 1);
    end
    cfg_write(CFG_CTRL, 16'h0004);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule